// File: doc/BRIEF.md
# Bitplane Pixel Pair Serializer

This block turns one 32-bit graphics memory word into a stream of pixel pairs. The word carries eight 4-bit pixels laid out as four bitplanes of eight bits each. Bit `p` of a pixel sits in plane `p`, and plane `p` occupies word bits `8p` to `8p+7`. Within a plane, even bit positions belong to the pixels of output bus A and odd positions belong to bus B.

A load strobe copies the whole word into a holding register on a rising clock edge. The block then shows pair 0 at once and moves through pairs 1, 2 and 3 on each clock where the step enable is high. The source word is latched, so the memory bus is free to fetch the next word while the four pairs are being shown. After the last pair has been stepped past, the valid flag drops and both buses read zero until the next load.

Top module: `bitplane_pair_serializer`

## Requirements
- R1: While reset is high at a clock edge, the block clears the held word, the pair index and the valid flag. After that edge, `pixValid`, `pixA` and `pixB` are all 0.
- R2: A clock edge with `loadWord` high stores `romWord`, sets `pixValid`, and sets the pair index to 0. This applies whatever `stepEn` is.
- R3: For pair index k (0..3), `pixA[p]` equals held word bit `8p+2k`, for p = 0..3.
- R4: For pair index k (0..3), `pixB[p]` equals held word bit `8p+2k+1`, for p = 0..3.
- R5: Pairs appear in the order k = 0, 1, 2, 3. The index moves up by one only at an edge where `pixValid` and `stepEn` are high and `loadWord` is low. At any other edge, the index and the outputs stay as they are.
- R6: A step taken while showing pair 3 clears `pixValid`. The flag then stays low until the next load.
- R7: A load during an active sequence replaces the held word at once and restarts at pair 0. This includes loads on consecutive cycles.
- R8: Changes on `romWord` at edges without a load have no effect on the outputs.
- R9: Whenever `pixValid` is low, `pixA` and `pixB` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadWord | input | 1 | Capture `romWord` and restart at pair 0 |
| stepEn | input | 1 | Advance to the next pixel pair |
| romWord | input | 32 | Bitplane word from graphics memory |
| pixA | output | 4 | Even pixel of the current pair |
| pixB | output | 4 | Odd pixel of the current pair |
| pixValid | output | 1 | A pair is being shown |

## Verification
The hardest cases to reach from the ports are a reload that lands on pair 3, and a reload at the same edge that would have retired the sequence. Both need the load to collide with a step at a chosen index. The stimulus walks a load-then-step pattern across every index, loads on consecutive cycles, and adds random sequences in which load and step are both high. Throughout, `romWord` is scrambled on every cycle without a load, so any leak from the live bus shows up as a mismatch.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef struct packed {
    logic clear;
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/bps_control.sv
module bps_control
  import bps_pkg::*;
#(
  parameter int STEPS = 4,
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadWord,
  input  logic             stepEn,
  output ctrlStrobe_t      strb,
  output logic [CNT_W-1:0] stepIdx,
  output logic             active
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic advance;
  logic lastStep;

  always_comb begin
    strb.clear   = rst;
    strb.capture = loadWord & ~rst;
    advance      = active & stepEn & ~loadWord;
    lastStep     = (stepIdx == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stepIdx <= '0;
      active  <= 1'b0;
    end else if (loadWord) begin
      stepIdx <= '0;
      active  <= 1'b1;
    end else if (advance) begin
      if (lastStep) begin
        active  <= 1'b0;
        stepIdx <= '0;
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    loadWord |=> (active && stepIdx == '0));
  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadWord && !(active && stepEn)) |=> ($stable(stepIdx) && $stable(active)));
  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (active && stepEn && !loadWord && stepIdx != LAST) |=> (active && stepIdx == $past(stepIdx) + 1'b1));
  // R6
  retire_chk: assert property (@(posedge clk) disable iff (rst)
    (active && stepEn && !loadWord && stepIdx == LAST) |=> !active);
endmodule

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int LANES  = 2,
  parameter int STEPS  = 4,
  localparam int WORD_W = PLANES * LANES * STEPS,
  localparam int STRIDE = LANES * STEPS,
  localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                     clk,
  input  ctrlStrobe_t              strb,
  input  logic [WORD_W-1:0]        romWord,
  input  logic [CNT_W-1:0]         stepIdx,
  input  logic                     active,
  output logic [LANES*PLANES-1:0]  lanePix
);
  logic [WORD_W-1:0] holdWord;

  always_ff @(posedge clk) begin
    if (strb.clear)        holdWord <= '0;
    else if (strb.capture) holdWord <= romWord;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
      always_comb begin
        int idx;
        idx = p * STRIDE + int'(stepIdx) * LANES + l;
        lanePix[l*PLANES + p] = active & holdWord[idx];
      end
    end
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (strb.clear)
    strb.capture |=> (holdWord == $past(romWord)));
  // R8
  held_stable_chk: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.capture |=> $stable(holdWord));
endmodule

// File: rtl/bitplane_pair_serializer.sv
module bitplane_pair_serializer
  import bps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int STEPS  = 4,
  localparam int LANES  = 2,
  localparam int WORD_W = PLANES * LANES * STEPS,
  localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadWord,
  input  logic              stepEn,
  input  logic [WORD_W-1:0] romWord,
  output logic [PLANES-1:0] pixA,
  output logic [PLANES-1:0] pixB,
  output logic              pixValid
);
  ctrlStrobe_t             strb;
  logic [CNT_W-1:0]        stepIdx;
  logic                    active;
  logic [LANES*PLANES-1:0] lanePix;

  bps_control #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .loadWord(loadWord), .stepEn(stepEn),
    .strb(strb), .stepIdx(stepIdx), .active(active)
  );

  bps_datapath #(.PLANES(PLANES), .LANES(LANES), .STEPS(STEPS)) u_data (
    .clk(clk), .strb(strb), .romWord(romWord), .stepIdx(stepIdx),
    .active(active), .lanePix(lanePix)
  );

  assign pixA     = lanePix[PLANES-1:0];
  assign pixB     = lanePix[2*PLANES-1:PLANES];
  assign pixValid = active;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pixValid && pixA == '0 && pixB == '0));
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pixValid |-> (pixA == '0 && pixB == '0));
endmodule

// File: tb/sim_bitplane_pair_serializer.sv
module sim_bitplane_pair_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadWord = 1'b0;
  logic        stepEn = 1'b0;
  logic [31:0] romWord = '0;
  logic [3:0]  pixA, pixB;
  logic        pixValid;

  int vectors = 0;
  int fails = 0;

  logic [31:0] mWord = '0;
  int          mIdx = 0;
  bit          mValid = 0;

  always #4 clk = ~clk;

  bitplane_pair_serializer u0 (
    .clk(clk), .rst(rst), .loadWord(loadWord), .stepEn(stepEn),
    .romWord(romWord), .pixA(pixA), .pixB(pixB), .pixValid(pixValid)
  );

  function automatic logic [3:0] refPix(logic [31:0] w, int k, int odd);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = w[8*p + 2*k + odd];
    return r;
  endfunction

  task automatic compare(string tag);
    logic [3:0] eA, eB;
    eA = mValid ? refPix(mWord, mIdx, 0) : 4'h0;
    eB = mValid ? refPix(mWord, mIdx, 1) : 4'h0;
    vectors++;
    if (pixValid !== mValid || pixA !== eA || pixB !== eB) begin
      fails++;
      $display("FAIL %s: got valid=%0b A=%h B=%h expected valid=%0b A=%h B=%h",
               tag, pixValid, pixA, pixB, mValid, eA, eB);
    end
  endtask

  // one clock: drive away from the edge, update model at the edge, check after
  task automatic tick(bit ld, bit en, logic [31:0] w, string tag);
    loadWord = ld;
    stepEn   = en;
    romWord  = w;
    @(posedge clk);
    if (rst) begin
      mWord = '0; mIdx = 0; mValid = 0;
    end else if (ld) begin
      mWord = w; mIdx = 0; mValid = 1;
    end else if (mValid && en) begin
      if (mIdx == 3) begin mValid = 0; mIdx = 0; end
      else mIdx++;
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(0, 0, 32'hFFFF_FFFF, "R1");
    tick(1, 1, 32'hDEAD_BEEF, "R1");
    rst = 1'b0;
    tick(0, 1, 32'h1234_5678, "R9");

    // R2 R3 R4 walking single bits reveal each mapping
    for (int b = 0; b < 32; b++) begin
      tick(1, 0, 32'h1 << b, "R2");
      for (int k = 0; k < 4; k++) tick(0, 1, $urandom, (k == 3) ? "R6" : "R3 R4");
    end

    // R5 gaps without step; R8 bus scrambled while holding
    tick(1, 0, 32'hA5C3_0F96, "R2");
    for (int k = 0; k < 12; k++) tick(0, (k % 3) == 2, $urandom, "R5 R8");
    tick(0, 1, $urandom, "R6");
    tick(0, 1, $urandom, "R9");

    // R7 back-to-back loads and reload at each index, including with step high
    for (int j = 0; j < 4; j++) tick(1, j[0], $urandom, "R7");
    for (int k = 0; k < 4; k++) begin
      tick(1, 1, $urandom, "R7");
      for (int s = 0; s < k; s++) tick(0, 1, $urandom, "R5");
      tick(1, 1, $urandom, "R7");
      tick(0, 1, $urandom, "R3 R4");
    end

    // R6 stays low until next load
    for (int k = 0; k < 6; k++) tick(0, 1, $urandom, "R6");

    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      tick(($urandom % 6) == 0, ($urandom % 4) != 0, $urandom, "R3 R4 R5 R7");

    // R1 reset mid-sequence
    tick(1, 0, 32'hFFFF_FFFF, "R2");
    rst = 1'b1;
    tick(0, 1, 32'hFFFF_FFFF, "R1");
    rst = 1'b0;
    tick(0, 1, 32'hFFFF_FFFF, "R1 R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule